// File: doc/BRIEF.md
# Period-Replay Frequency Multiplier

This block turns a slow square-wave reference into a square wave at an integer multiple of its frequency. The multiple is three by default. It does this without any loop filter or oscillator. A slow counter, advanced once every 2·MULT system clocks, measures the time between reference rising edges. At each rising edge the result is frozen in a holding register. A second counter runs at the full clock rate and plays that count back. Each time it completes the count, it toggles the output, so each output half-period lasts the held count in clocks.

Every reference rising edge also forces the output high and restarts the playback counter. This ties the output phase to the reference on every cycle, and the output is usable after a single complete reference period. The reference is asynchronous. It is brought into the clock domain by a two-flop synchronizer and a rising-edge detector. Periods too short to give a nonzero count and periods too long for the counter width are both reported as not locked. Too-long periods also raise an overflow flag.

Top module: `freq_mult`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mult_out`, `locked` and `overflow` are low.
- R2: A reference rising edge takes effect on the third rising clock edge that samples `ref_in` high. Its effects are the latch of the count, the forced-high output and the restart of playback.
- R3: The held count H equals floor(P / (2·MULT)), where P is the number of clock cycles between two successive effective rising edges. A prescaler step that falls on the latching cycle itself is included in H. The prescale phase restarts at every rising edge.
- R4: While locked, `mult_out` is high for exactly H cycles and then low for exactly H cycles, alternating. The pattern counts from the cycle at which a rising edge takes effect.
- R5: Every effective rising edge that leaves the block locked drives `mult_out` high on that cycle and restarts the H-cycle phase. This applies even when the output was mid-phase.
- R6: `locked` stays low until the second effective rising edge after reset. While `locked` is low, `mult_out` is low.
- R7: If H is 0, meaning P < 2·MULT, the latch leaves `locked` low and `mult_out` low.
- R8: The measurement counter saturates at all ones (2^CNT_W − 1). A latched count at all ones sets `overflow` high and `locked` low. Both flags change only at effective rising edges, so the next in-range period clears `overflow` and restores lock.
- R9: After the reference period changes, the new H takes effect only at the rising edge that ends the first period of the new length. The output keeps the old H until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Asynchronous reference square wave |
| mult_out | output | 1 | Multiplied square wave, low while not locked |
| locked | output | 1 | Last latched period was nonzero and in range |
| overflow | output | 1 | Last latched period saturated the measurement counter |

## Verification
Two events can fall on the same cycle. The first is the latch of the measured count, which coincides with clearing the measurement counter. The second is a prescaler step that increments the counter on that very cycle. The bench provokes the collision with reference periods that are exact multiples of six clocks, such as 600 and 6 cycles. In those cases, losing the pre-clear step would show up as H = 99 instead of 100, or as no lock at all. The same periods also make the playback counter's final toggle coincide with the forced-high resynchronization. The bench judges every cycle against a model of the output pattern derived from H, so a one-cycle slip in either collision shows up as a wrong output level.

// File: rtl/freq_mult_pkg.sv
package freq_mult_pkg;

    // Two-stage synchronizer plus one delayed copy for edge detection
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_state_t;

    // Per-period status recorded at each latch
    typedef struct packed {
        logic armed;
        logic locked;
        logic ovf;
    } meter_flags_t;

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync
    import freq_mult_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic rise
);
    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = ref_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.s3;
endmodule

// File: rtl/prescale_tick.sv
module prescale_tick #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart)                st_d.cnt = '0;
        else if (st_q.cnt == LAST)  st_d.cnt = '0;
        else                        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick = (st_q.cnt == LAST);
endmodule

// File: rtl/period_meter.sv
module period_meter
    import freq_mult_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rise,
    output logic [CNT_W-1:0] hold,
    output logic             locked,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL = '1;

    typedef struct packed {
        logic [CNT_W-1:0] meas;
        logic [CNT_W-1:0] hold;
        meter_flags_t     fl;
    } meter_state_t;

    meter_state_t     st_d, st_q;
    logic [CNT_W-1:0] stepped;
    logic             sat;

    always_comb begin
        // count including any step landing on this cycle, saturating
        stepped = (st_q.meas == FULL) ? FULL : st_q.meas + CNT_W'(tick);
        sat     = (stepped == FULL);
        st_d    = st_q;
        if (rise) begin
            st_d.hold      = stepped;
            st_d.meas      = '0;
            st_d.fl.armed  = 1'b1;
            st_d.fl.locked = st_q.fl.armed & (stepped != '0) & ~sat;
            st_d.fl.ovf    = st_q.fl.armed & sat;
        end else begin
            st_d.meas = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hold   = st_q.hold;
    assign locked = st_q.fl.locked;
    assign ovf    = st_q.fl.ovf;
endmodule

// File: rtl/replay_gen.sv
module replay_gen #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic [CNT_W-1:0] hold,
    output logic             tog
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tog;
    } replay_state_t;

    replay_state_t    st_d, st_q;
    logic [CNT_W-1:0] term;

    always_comb begin
        term = hold - CNT_W'(1);
        st_d = st_q;
        if (rise) begin
            st_d.cnt = '0;
            st_d.tog = 1'b1;
        end else if (st_q.cnt == term) begin
            st_d.cnt = '0;
            st_d.tog = ~st_q.tog;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tog = st_q.tog;
endmodule

// File: rtl/freq_mult.sv
module freq_mult #(
    parameter int MULT  = 3,
    parameter int CNT_W = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic mult_out,
    output logic locked,
    output logic overflow
);
    localparam int DIV = 2 * MULT;

    logic             rise_w;
    logic             tick_w;
    logic             tog_w;
    logic [CNT_W-1:0] hold_w;

    ref_edge_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .rise   (rise_w)
    );

    prescale_tick #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (rise_w),
        .tick    (tick_w)
    );

    period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_w),
        .rise   (rise_w),
        .hold   (hold_w),
        .locked (locked),
        .ovf    (overflow)
    );

    replay_gen #(.CNT_W(CNT_W)) u_replay (
        .clk  (clk),
        .rst  (rst),
        .rise (rise_w),
        .hold (hold_w),
        .tog  (tog_w)
    );

    assign mult_out = tog_w & locked;
endmodule

// File: rtl/freq_mult_chk.sv
module freq_mult_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             rise,
    input logic [CNT_W-1:0] hold,
    input logic             mult_out,
    input logic             locked,
    input logic             overflow
);
    // R6, R7: no output activity without lock
    a_r6_quiet_unlocked: assert property (@(posedge clk) disable iff (rst)
        !locked |-> !mult_out);

    // R8: a saturated period never counts as locked
    a_r8_ovf_not_locked: assert property (@(posedge clk) disable iff (rst)
        overflow |-> !locked);

    // R5: a rising edge that leaves lock set forces the output high
    a_r5_resync_high: assert property (@(posedge clk) disable iff (rst)
        rise |=> (locked |-> mult_out));

    // R8: status flags change only at a latch
    a_r8_flags_at_latch: assert property (@(posedge clk) disable iff (rst)
        !rise |=> ($stable(locked) && $stable(overflow)));

    // R9: the held count changes only at a latch
    a_r9_hold_at_latch: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(hold));

    // R4: while locked with a count above one, the output cannot toggle on consecutive cycles
    a_r4_min_phase: assert property (@(posedge clk) disable iff (rst)
        (locked && hold > CNT_W'(1) && !rise && $changed(mult_out)) |=> (rise || $stable(mult_out)));
endmodule

bind freq_mult freq_mult_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise_w),
    .hold     (hold_w),
    .mult_out (mult_out),
    .locked   (locked),
    .overflow (overflow)
);

// File: tb/tb_freq_mult.sv
module tb_freq_mult;
    localparam int MULT  = 3;
    localparam int CNT_W = 10;
    localparam int DIV   = 2 * MULT;
    localparam int FULL  = (1 << CNT_W) - 1;
    localparam int NV    = 11;

    // reference period (cycles), number of periods, requirement tag
    localparam int VP [NV] = '{600, 600, 604, 61, 12, 7, 5, 6, 6200, 60, 600};
    localparam int VN [NV] = '{3,   4,   4,   6,  8,  8, 6, 6, 3,    5,  2};
    localparam int VR [NV] = '{6,   4,   3,   9,  4,  3, 7, 5, 8,    8,  5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic mult_out, locked, overflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m1, m2, m3, armed, lk, ov, hh, cnt, pos;

    always #5 clk = ~clk;

    freq_mult #(.MULT(MULT), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .ref_in(ref_in),
        .mult_out(mult_out), .locked(locked), .overflow(overflow)
    );

    task automatic check(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m1 = 0; m2 = 0; m3 = 0; armed = 0; lk = 0; ov = 0; hh = 0; cnt = 0; pos = 0;
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic tick(input logic r, input int req);
        int h;
        ref_in = r;
        @(posedge clk);
        if (rst) model_reset();
        else begin
            if (m2 == 1 && m3 == 0) begin        // R2: third edge seeing ref high
                h = (cnt + 1) / DIV;             // R3: floor(P/2N)
                if (h > FULL) h = FULL;
                if (armed == 1) begin
                    lk = (h != 0 && h != FULL) ? 1 : 0;
                    ov = (h == FULL) ? 1 : 0;
                end
                hh = h; armed = 1; cnt = 0; pos = 0;
            end else begin
                cnt++; pos++;
            end
            m3 = m2; m2 = m1; m1 = int'(r);
        end
        @(negedge clk);
        check(req, "mult_out", int'(mult_out), (lk == 1 && ((pos / hh) % 2) == 0) ? 1 : 0);
        check(req, "locked",   int'(locked), lk);
        check(req, "overflow", int'(overflow), ov);
    endtask

    task automatic periods(input int p, input int n, input int req);
        for (int k = 0; k < n; k++)
            for (int c = 0; c < p; c++)
                tick(c < p / 2, req);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        // R1: reset state
        rst = 1'b1;
        for (int i = 0; i < 4; i++) tick(1'b0, 1);
        rst = 1'b0;
        tick(1'b0, 1);

        // vector table
        for (int v = 0; v < NV; v++) periods(VP[v], VN[v], VR[v]);

        // directed: reset mid-run, then relock only after two edges (R1, R6)
        rst = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b0, 1);
        rst = 1'b0;
        periods(600, 1, 6);
        check(6, "locked after one edge", int'(locked), 0);
        periods(600, 2, 6);
        check(6, "locked after relock", int'(locked), 1);

        // directed: overflow recovery (R8)
        periods(6138, 2, 8);
        check(8, "overflow at exact full count", int'(overflow), 1);
        periods(90, 2, 8);
        check(8, "overflow cleared", int'(overflow), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule